// File: doc/BRIEF.md
# Oldest-First Issue Scheduler With Wait, Ready and Execute Tracking

This block holds instructions that have been dispatched but not yet written back. Each instruction carries a sequence index. It sits in one of a fixed number of slots, and each slot runs a small state machine with four named states: SLOT_FREE (empty), SLOT_WAIT (operands outstanding), SLOT_READY (eligible for issue) and SLOT_EXEC (issued, waiting for writeback). The named transitions are:

- ALLOC: SLOT_FREE to SLOT_WAIT or SLOT_READY, on dispatch.
- PROMOTE: SLOT_WAIT to SLOT_READY, on a per-slot wakeup.
- ISSUE: SLOT_READY to SLOT_EXEC, on selection.
- RETIRE: SLOT_EXEC to SLOT_FREE, on a writeback whose index matches the slot.

A dispatch stage offers one instruction per cycle together with a flag that says whether all its operands are already available. Operand and memory-dependence logic outside the block raises a wakeup bit for each slot whose dependencies have resolved. Promotion takes effect at the clock edge, so the entry is ready from the start of the next cycle. When the execution resources signal availability, the scheduler issues at most one ready instruction per cycle. It always chooses the oldest one. Age is measured as the distance of the sequence index from an externally supplied oldest pointer, modulo the index range, so ordering stays correct when the index wraps. A writeback carrying the index of an executing entry frees its slot. When every slot is occupied, the block refuses dispatch and flags any attempt that arrives anyway.

Top module: `issue_sched`

## Requirements
- R1: After reset every slot is SLOT_FREE, `disp_ready` is 1, `full` is 0 and `issue_valid` is 0.
- R2: A dispatch accepted while `disp_opnd_rdy` is 1 puts the entry in SLOT_READY on the next cycle; otherwise it goes to SLOT_WAIT. The entry is always placed in the lowest-numbered free slot. Slot i reports its state on `slot_state[2i+1:2i]`, with FREE=0, WAIT=1, READY=2 and EXEC=3.
- R3: If `wake_vec[i]` is 1 while slot i is in SLOT_WAIT, the slot is in SLOT_READY on the next cycle. A wakeup to a slot in any other state has no effect.
- R4: While `res_avail` is 1 and at least one slot is SLOT_READY, `issue_valid` is 1 in that same cycle. `issue_seq` then carries the index of the ready entry with the smallest age, and that slot is SLOT_EXEC on the next cycle.
- R5: While `res_avail` is 0, `issue_valid` is 0 and no ready entry changes state.
- R6: A writeback whose `wb_seq` matches a SLOT_EXEC entry returns that slot to SLOT_FREE on the next cycle. A writeback that matches only a non-executing entry has no effect.
- R7: When all slots are occupied, `full` is 1 and `disp_ready` is 0. A dispatch in such a cycle is dropped, leaves every slot unchanged, and raises `disp_drop` in that same cycle. This holds even if a writeback frees a slot at the same edge.
- R8: Age is computed as (seq - `oldest_seq`) mod 2^SEQ_W. For example, with an oldest pointer of 60, index 62 issues before index 1.
- R9: At most one entry leaves SLOT_READY for SLOT_EXEC per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_seq | input | SEQ_W | Sequence index of the dispatched instruction |
| disp_opnd_rdy | input | 1 | All operands of the dispatched instruction are available |
| disp_ready | output | 1 | A free slot exists, so dispatch is accepted |
| disp_drop | output | 1 | A dispatch arrived while full and was discarded |
| wake_vec | input | NUM_SLOTS | Per-slot operand/memory wakeup |
| oldest_seq | input | SEQ_W | Oldest in-flight sequence index, the reference point for age |
| res_avail | input | 1 | Execution resources accept an issue this cycle |
| issue_valid | output | 1 | An entry issues this cycle |
| issue_seq | output | SEQ_W | Sequence index of the issuing entry |
| wb_valid | input | 1 | Writeback event |
| wb_seq | input | SEQ_W | Sequence index reaching writeback |
| slot_state | output | 2*NUM_SLOTS | Per-slot state code |
| full | output | 1 | Every slot is occupied |

## Verification
Two functions can meet in one cycle. The first pair is the ISSUE of one entry and the PROMOTE of another: the bench raises a wakeup on a waiting slot while a different ready slot is being issued. It then checks that only the already-ready entry issues, and that the woken entry issues in the following cycle. The second pair is a RETIRE and a dispatch that arrive together while every slot is full. The dispatch must be dropped and flagged even though a slot becomes free at that edge. A behavioural model of the slots predicts every output on every cycle, and the bench compares the design against that prediction.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_EXEC  = 2'd3
    } slot_st_t;

endpackage

// File: rtl/issue_sched_slot.sv
module issue_sched_slot
    import issue_sched_pkg::*;
#(
    parameter int SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             alloc_rdy_i,
    input  logic [SEQ_W-1:0] alloc_seq_i,
    input  logic             wake_i,
    input  logic             grant_i,
    input  logic             wb_valid_i,
    input  logic [SEQ_W-1:0] wb_seq_i,
    output slot_st_t         state_o,
    output logic [SEQ_W-1:0] seq_o,
    output logic             is_ready_o,
    output logic             is_free_o
);

    slot_st_t         state_q, state_d;
    logic [SEQ_W-1:0] seq_q, seq_d;
    logic             wb_hit;

    assign wb_hit = wb_valid_i && (wb_seq_i == seq_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        seq_d   = seq_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc_i) begin
                    state_d = alloc_rdy_i ? SLOT_READY : SLOT_WAIT;
                    seq_d   = alloc_seq_i;
                end
            end
            SLOT_WAIT: begin
                if (wake_i) state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (grant_i) state_d = SLOT_EXEC;
            end
            SLOT_EXEC: begin
                if (wb_hit) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
            seq_q   <= '0;
        end else begin
            state_q <= state_d;
            seq_q   <= seq_d;
        end
    end

    // outputs
    always_comb begin
        state_o    = state_q;
        seq_o      = seq_q;
        is_ready_o = (state_q == SLOT_READY);
        is_free_o  = (state_q == SLOT_FREE);
    end

    AST_ALLOC_FROM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> state_q == SLOT_FREE); // R2
    AST_WAKE_PROMOTE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_WAIT && wake_i) |=> state_q == SLOT_READY); // R3
    AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> state_q == SLOT_READY); // R4
    AST_GRANT_EXECUTES: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |=> state_q == SLOT_EXEC); // R4
    AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_EXEC && wb_valid_i && wb_seq_i == seq_q) |=> state_q == SLOT_FREE); // R6

endmodule

// File: rtl/issue_sched_alloc.sv
module issue_sched_alloc #(
    parameter int NUM_SLOTS = 8
) (
    input  logic [NUM_SLOTS-1:0] free_vec_i,
    output logic [NUM_SLOTS-1:0] first_free_o,
    output logic                 full_o
);

    always_comb begin
        logic found;
        found        = 1'b0;
        first_free_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (free_vec_i[i] && !found) begin
                first_free_o[i] = 1'b1;
                found           = 1'b1;
            end
        end
        full_o = !found;
    end

endmodule

// File: rtl/issue_sched_pick.sv
module issue_sched_pick #(
    parameter int NUM_SLOTS = 8,
    parameter int SEQ_W     = 6
) (
    input  logic [NUM_SLOTS-1:0]            ready_vec_i,
    input  logic [NUM_SLOTS-1:0][SEQ_W-1:0] seq_vec_i,
    input  logic [SEQ_W-1:0]                oldest_i,
    output logic [NUM_SLOTS-1:0]            pick_o,
    output logic [SEQ_W-1:0]                pick_seq_o,
    output logic                            any_o
);

    logic [NUM_SLOTS-1:0][SEQ_W-1:0] age;

    // wrap-aware distance from the oldest pointer
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_age
        assign age[g] = seq_vec_i[g] - oldest_i;
    end

    always_comb begin
        logic [SEQ_W-1:0] best_age;
        int               best;
        best       = -1;
        best_age   = '1;
        pick_o     = '0;
        pick_seq_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ready_vec_i[i] && (best < 0 || age[i] < best_age)) begin
                best     = i;
                best_age = age[i];
            end
        end
        any_o = (best >= 0);
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (i == best) begin
                pick_o[i]  = 1'b1;
                pick_seq_o = seq_vec_i[i];
            end
        end
    end

endmodule

// File: rtl/issue_sched.sv
module issue_sched
    import issue_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SEQ_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [SEQ_W-1:0]       disp_seq,
    input  logic                   disp_opnd_rdy,
    output logic                   disp_ready,
    output logic                   disp_drop,
    input  logic [NUM_SLOTS-1:0]   wake_vec,
    input  logic [SEQ_W-1:0]       oldest_seq,
    input  logic                   res_avail,
    output logic                   issue_valid,
    output logic [SEQ_W-1:0]       issue_seq,
    input  logic                   wb_valid,
    input  logic [SEQ_W-1:0]       wb_seq,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic                   full
);

    localparam int ST_W = 2;

    logic [NUM_SLOTS-1:0]            free_vec, ready_vec, first_free, alloc_vec;
    logic [NUM_SLOTS-1:0]            pick_vec, grant_vec;
    logic [NUM_SLOTS-1:0][SEQ_W-1:0] seq_vec;
    logic [SEQ_W-1:0]                pick_seq;
    logic                            any_ready, full_w;
    slot_st_t                        st_vec [NUM_SLOTS];

    issue_sched_alloc #(.NUM_SLOTS(NUM_SLOTS)) u_alloc (
        .free_vec_i   (free_vec),
        .first_free_o (first_free),
        .full_o       (full_w)
    );

    issue_sched_pick #(.NUM_SLOTS(NUM_SLOTS), .SEQ_W(SEQ_W)) u_pick (
        .ready_vec_i (ready_vec),
        .seq_vec_i   (seq_vec),
        .oldest_i    (oldest_seq),
        .pick_o      (pick_vec),
        .pick_seq_o  (pick_seq),
        .any_o       (any_ready)
    );

    assign alloc_vec = (disp_valid && !full_w) ? first_free : '0;
    assign grant_vec = res_avail ? pick_vec : '0;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        issue_sched_slot #(.SEQ_W(SEQ_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (alloc_vec[g]),
            .alloc_rdy_i (disp_opnd_rdy),
            .alloc_seq_i (disp_seq),
            .wake_i      (wake_vec[g]),
            .grant_i     (grant_vec[g]),
            .wb_valid_i  (wb_valid),
            .wb_seq_i    (wb_seq),
            .state_o     (st_vec[g]),
            .seq_o       (seq_vec[g]),
            .is_ready_o  (ready_vec[g]),
            .is_free_o   (free_vec[g])
        );
        assign slot_state[g*ST_W +: ST_W] = st_vec[g];
    end

    always_comb begin
        full        = full_w;
        disp_ready  = !full_w;
        disp_drop   = disp_valid && full_w;
        issue_valid = res_avail && any_ready;
        issue_seq   = pick_seq;
    end

    AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_vec)); // R9
    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_avail |-> !issue_valid); // R5
    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (&(~free_vec)) |-> alloc_vec == '0); // R7

endmodule

// File: tb/issue_sched_bench.sv
module issue_sched_bench;

    localparam int N = 8;
    localparam int W = 6;
    localparam int MASK = (1 << W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             disp_valid = 1'b0;
    logic [W-1:0]     disp_seq = '0;
    logic             disp_opnd_rdy = 1'b0;
    logic             disp_ready, disp_drop, issue_valid, full;
    logic [N-1:0]     wake_vec = '0;
    logic [W-1:0]     oldest_seq = '0;
    logic             res_avail = 1'b0;
    logic [W-1:0]     issue_seq;
    logic             wb_valid = 1'b0;
    logic [W-1:0]     wb_seq = '0;
    logic [2*N-1:0]   slot_state;

    int n_checks = 0;
    int n_fail   = 0;
    int m_st [N];
    int m_seq [N];

    always #4 clk = ~clk;

    issue_sched #(.NUM_SLOTS(N), .SEQ_W(W)) u_issue_sched (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_seq(disp_seq),
        .disp_opnd_rdy(disp_opnd_rdy), .disp_ready(disp_ready), .disp_drop(disp_drop),
        .wake_vec(wake_vec), .oldest_seq(oldest_seq), .res_avail(res_avail),
        .issue_valid(issue_valid), .issue_seq(issue_seq), .wb_valid(wb_valid),
        .wb_seq(wb_seq), .slot_state(slot_state), .full(full)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag);
        int m_full, m_free, pick, best, age, exp_iv;
        int n_st [N];
        logic [2*N-1:0] exp_ss;
        @(negedge clk);
        m_full = 1; m_free = -1; pick = -1; best = 1 << 30;
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 0) begin
                m_full = 0;
                if (m_free < 0) m_free = i;
            end
            if (m_st[i] == 2) begin
                age = (m_seq[i] - int'(oldest_seq)) & MASK;
                if (age < best) begin best = age; pick = i; end
            end
        end
        exp_iv = (res_avail && pick >= 0) ? 1 : 0;
        exp_ss = '0;
        for (int i = 0; i < N; i++) exp_ss[2*i +: 2] = m_st[i][1:0];
        chk(tag, "full", int'(full), m_full);
        chk(tag, "disp_ready", int'(disp_ready), 1 - m_full);
        chk(tag, "disp_drop", int'(disp_drop), (disp_valid && m_full == 1) ? 1 : 0);
        chk(tag, "issue_valid", int'(issue_valid), exp_iv);
        if (exp_iv == 1) chk(tag, "issue_seq", int'(issue_seq), m_seq[pick]);
        chk(tag, "slot_state", int'(slot_state), int'(exp_ss));
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            n_st[i] = m_st[i];
            case (m_st[i])
                0: if (disp_valid && m_full == 0 && i == m_free) begin
                       n_st[i] = disp_opnd_rdy ? 2 : 1;
                       m_seq[i] = int'(disp_seq);
                   end
                1: if (wake_vec[i]) n_st[i] = 2;
                2: if (exp_iv == 1 && i == pick) n_st[i] = 3;
                default: if (wb_valid && int'(wb_seq) == m_seq[i]) n_st[i] = 0;
            endcase
        end
        for (int i = 0; i < N; i++) m_st[i] = n_st[i];
        #1;
    endtask

    task automatic idle();
        disp_valid = 0; wake_vec = '0; res_avail = 0; wb_valid = 0;
    endtask

    task automatic disp(input int s, input logic r);
        idle();
        disp_valid = 1; disp_seq = W'(s); disp_opnd_rdy = r;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_seq[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step("R1");
        // R2: waiting and ready dispatch, lowest free slot
        disp(10, 0); step("R2");
        disp(11, 1); step("R2");
        idle(); step("R2");
        // R4 with R3 in the same cycle: slot1 issues while slot0 is woken
        idle(); res_avail = 1; wake_vec = 8'h01; step("R4");
        idle(); res_avail = 1; step("R3");
        // R3: wakeups to executing and free slots have no effect
        idle(); wake_vec = '1; step("R3");
        idle(); step("R3");
        // R6: retire, then re-use of the lowest free slot
        idle(); wb_valid = 1; wb_seq = 11; step("R6");
        disp(20, 1); step("R2");
        idle(); wb_valid = 1; wb_seq = 20; step("R6");
        idle(); step("R6");
        // R5: no issue without resources
        idle(); step("R5");
        idle(); step("R5");
        // R7: fill, drop while full, drop alongside a retire
        for (int s = 30; s < 36; s++) begin disp(s, 1); step("R7"); end
        disp(40, 1); step("R7");
        disp(41, 1); wb_valid = 1; wb_seq = 10; step("R7");
        disp(41, 1); step("R7");
        // R9: one issue per cycle, oldest first
        for (int k = 0; k < 9; k++) begin idle(); res_avail = 1; step("R9"); end
        foreach (m_seq[i]) begin idle(); wb_valid = 1; wb_seq = W'(m_seq[i]); step("R6"); end
        idle(); step("R6");
        // R8: wrap-around age relative to the oldest pointer
        oldest_seq = 60;
        disp(1, 1); step("R8");
        disp(62, 1); step("R8");
        disp(63, 0); step("R8");
        idle(); res_avail = 1; wake_vec = 8'h04; step("R8");
        idle(); res_avail = 1; step("R8");
        idle(); res_avail = 1; step("R8");
        idle(); step("R8");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule